// File: doc/BRIEF.md
# Quad-Pad Programmable I/O Cell with 2:1 Gearbox

This block sits between core logic and four external pads, grouped into two pairs. Each pad has an input side and an output side. On the input side, a capture element runs as either an edge-triggered flip-flop or a level-sensitive latch. An address/data splitter steers a multiplexed bus into separate address and data registers. A double-edge sampler presents both halves of each clock period to the core as one 2-bit word. A 2:1 deserializer packs two consecutive bits into one word for the core.

On the output side, each pad has an output flip-flop fed by a two-way selector of core signals, and an optional inverter. A double-edge launcher drives one bit in the high half of the clock and another in the low half. A 2:1 serializer emits a core word one bit per clock, least significant bit first. The output enable can be active-high, active-low or forced on, and it can be registered or passed straight through.

Each pair has its own clock enable and its own local set/reset. A single global set/reset acts on both pairs and takes priority over everything. The serializer and deserializer share a phase state machine with two states, PH_EVEN and PH_ODD. It moves from PH_EVEN to PH_ODD and from PH_ODD to PH_EVEN on every rising edge. Global set/reset forces it into PH_EVEN.

Top module: `pio_quad`

## Requirements
- R1: While `gsr` is high at a rising edge, every capture and output register returns to its set/reset value (0 by default), the registered output enable clears and the phase machine returns to PH_EVEN, whatever `ce` and `lsr` are.
- R2: `lsr[p]` high at a rising edge resets only the registers of pair p (pads 2p and 2p+1), overriding `ce[p]`; the other pair carries on.
- R3: With `ce[p]` low, the registers of pair p hold their values across a rising edge.
- R4: With `latch_mode`=0, `in_q` takes the pad value at each rising edge. With `latch_mode`=1, `in_q` follows the pad while the clock is high and holds while it is low.
- R5: With `demux_en`=1, a rising edge with `ad_strobe` high loads the pad into `addr_q` and leaves `data_q` unchanged. A rising edge with `ad_strobe` low loads `data_q` and leaves `addr_q` unchanged.
- R6: With `out_mode`=0, `pad_out` shows, one edge after the data is applied, `core_b` when `out_sel`=1 and `core_a` otherwise, XOR `out_invert`.
- R7: `ts_mode` 0 gives `pad_oe`=`core_oe`, 1 gives `~core_oe` and 2 gives all ones. With `ts_reg`=0 this follows combinationally. With `ts_reg`=1 it appears one rising edge later.
- R8: For pad i, `ddr_word[2i]` is the value sampled at a rising edge and `ddr_word[2i+1]` the value sampled at the following falling edge. The pair is updated at the next rising edge.
- R9: With `out_mode`=1, after a rising edge `pad_out` shows the `core_a` value captured there while the clock is high, and the `core_b` value while it is low.
- R10: `gear_phase` alternates 0/1 on each rising edge. The bit sampled at the edge leaving phase 0 goes to `gear_word[2i]` and the next bit to `gear_word[2i+1]`. `gear_valid` pulses for one cycle as the word updates.
- R11: With `out_mode`=2, the edge leaving phase 0 loads `{core_b, core_a}`. `pad_out` shows `core_a` for one cycle and then `core_b`, and core inputs at the phase-1 edge are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| gsr | input | 1 | Global set/reset, synchronous, active high |
| lsr | input | 2 | Local set/reset, one per pair |
| ce | input | 2 | Clock enable, one per pair |
| latch_mode | input | 1 | 1 selects latch capture for `in_q` |
| demux_en | input | 1 | Enables the address/data splitter |
| ad_strobe | input | 1 | High for the address phase |
| pad_in | input | 4 | Pad input values |
| in_q | output | 4 | Captured pad values |
| addr_q | output | 4 | Address-phase register |
| data_q | output | 4 | Data-phase register |
| ddr_word | output | 8 | Double-edge words, 2 bits per pad |
| gear_word | output | 8 | Deserialized words, 2 bits per pad |
| gear_valid | output | 1 | One-cycle pulse on a new deserialized word |
| gear_phase | output | 1 | Current gearbox phase (0 = PH_EVEN) |
| out_mode | input | 2 | 0 single edge, 1 double edge, 2 serializer |
| out_sel | input | 1 | Output selector: 1 picks `core_b` |
| out_invert | input | 1 | Inverts the pad data |
| ts_mode | input | 2 | 0 active-high, 1 active-low, 2 always enabled |
| ts_reg | input | 1 | 1 registers the output enable |
| core_a | input | 4 | First core output source / low bit |
| core_b | input | 4 | Second core output source / high bit |
| core_oe | input | 4 | Core output enable request |
| pad_out | output | 4 | Pad output values |
| pad_oe | output | 4 | Pad output enables |

## Verification
A phase machine off by one cycle would show up at the ports within two edges. The deserialized word would come out with its two bits swapped, and the serializer would drive `core_b` before `core_a`. Reset or enable applied to the wrong pair would show on `in_q` after the first edge, as a pad that is cleared or frozen when it should not be. A double-edge sampler tied to the wrong edge would put the wrong bit order on `ddr_word` one edge after the falling sample. A mis-steered splitter would overwrite `addr_q` during a data phase at that same edge.

// File: rtl/pio_pkg.sv
package pio_pkg;
    typedef enum logic [1:0] {
        OM_SDR  = 2'd0,
        OM_DDR  = 2'd1,
        OM_GEAR = 2'd2
    } out_mode_e;

    typedef enum logic [1:0] {
        TS_HIGH = 2'd0,
        TS_LOW  = 2'd1,
        TS_ON   = 2'd2
    } ts_mode_e;

    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } gb_phase_e;
endpackage

// File: rtl/pio_phase_fsm.sv
module pio_phase_fsm
    import pio_pkg::*;
(
    input  logic clk,
    input  logic gsr,
    output logic phase_odd,
    output logic word_valid
);
    gb_phase_e state_q, state_d;
    logic      valid_q;

    always_comb begin
        unique case (state_q)
            PH_EVEN: state_d = PH_ODD;
            PH_ODD:  state_d = PH_EVEN;
            default: state_d = PH_EVEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (gsr) state_q <= PH_EVEN;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (gsr) valid_q <= 1'b0;
        else     valid_q <= (state_q == PH_ODD);
    end

    assign phase_odd  = (state_q == PH_ODD);
    assign word_valid = valid_q;

    // R10: a valid pulse lasts exactly one cycle
    p_valid_single_r10: assert property (@(posedge clk) disable iff (gsr)
        word_valid |=> !word_valid);
    // R10: phase alternates on every edge out of reset
    p_phase_toggle_r10: assert property (@(posedge clk) disable iff (gsr)
        phase_odd |=> !phase_odd);
endmodule

// File: rtl/pio_in_slice.sv
module pio_in_slice #(
    parameter logic INIT = 1'b0
) (
    input  logic       clk,
    input  logic       gsr,
    input  logic       lsr,
    input  logic       ce,
    input  logic       latch_mode,
    input  logic       demux_en,
    input  logic       ad_strobe,
    input  logic       pad,
    input  logic       phase_odd,
    output logic       in_q,
    output logic       addr_q,
    output logic       data_q,
    output logic [1:0] ddr_word,
    output logic [1:0] gear_word
);
    logic ff_q, lat_q, rise_q, fall_q, gb_first_q;
    logic [1:0] ddr_q, gear_q;
    logic clr;

    assign clr = gsr | lsr;

    always_ff @(posedge clk) begin
        if (clr) begin
            ff_q       <= INIT;
            addr_q     <= INIT;
            data_q     <= INIT;
            rise_q     <= INIT;
            ddr_q      <= {INIT, INIT};
            gb_first_q <= INIT;
            gear_q     <= {INIT, INIT};
        end else if (ce) begin
            ff_q   <= pad;
            rise_q <= pad;
            ddr_q  <= {fall_q, rise_q};
            if (demux_en) begin
                if (ad_strobe) addr_q <= pad;
                else           data_q <= pad;
            end
            if (!phase_odd) gb_first_q <= pad;
            else            gear_q     <= {pad, gb_first_q};
        end
    end

    always_ff @(negedge clk) begin
        if (clr)     fall_q <= INIT;
        else if (ce) fall_q <= pad;
    end

    always_latch begin
        if (clr)                           lat_q = INIT;
        else if (clk && ce && latch_mode)  lat_q = pad;
    end

    assign in_q      = latch_mode ? lat_q : ff_q;
    assign ddr_word  = ddr_q;
    assign gear_word = gear_q;

    // R3: a disabled pair keeps its registered input state
    p_ce_hold_r3: assert property (@(posedge clk) disable iff (gsr)
        (!ce && !lsr) |=> ($stable(ff_q) && $stable(addr_q) && $stable(data_q)));
    // R5: an address phase never disturbs the data register
    p_addr_keeps_data_r5: assert property (@(posedge clk) disable iff (gsr)
        (ce && !lsr && demux_en && ad_strobe) |=> $stable(data_q));
endmodule

// File: rtl/pio_out_slice.sv
module pio_out_slice
    import pio_pkg::*;
#(
    parameter logic INIT = 1'b0
) (
    input  logic      clk,
    input  logic      gsr,
    input  logic      lsr,
    input  logic      ce,
    input  out_mode_e mode,
    input  logic      sel,
    input  logic      invert,
    input  ts_mode_e  ts_mode,
    input  logic      ts_reg,
    input  logic      core_a,
    input  logic      core_b,
    input  logic      core_oe,
    input  logic      phase_odd,
    output logic      pad_out,
    output logic      pad_oe
);
    logic q, hold_q, r0_q, r1_q, oe_q, oe_raw, bit_out;

    always_comb begin
        unique case (ts_mode)
            TS_HIGH: oe_raw = core_oe;
            TS_LOW:  oe_raw = ~core_oe;
            default: oe_raw = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (gsr || lsr) begin
            q      <= INIT;
            hold_q <= INIT;
            r0_q   <= INIT;
            r1_q   <= INIT;
            oe_q   <= 1'b0;
        end else if (ce) begin
            oe_q <= oe_raw;
            unique case (mode)
                OM_DDR: begin
                    r0_q <= core_a;
                    r1_q <= core_b;
                end
                OM_GEAR: begin
                    if (!phase_odd) begin
                        q      <= core_a;
                        hold_q <= core_b;
                    end else begin
                        q <= hold_q;
                    end
                end
                default: q <= sel ? core_b : core_a;
            endcase
        end
    end

    assign bit_out = (mode == OM_DDR) ? (clk ? r0_q : r1_q) : q;
    assign pad_out = bit_out ^ invert;
    assign pad_oe  = ts_reg ? oe_q : oe_raw;

    // R2: local reset leaves the registered enable off
    p_lsr_oe_off_r2: assert property (@(posedge clk) disable iff (gsr)
        (lsr && ts_reg) |=> (!pad_oe || !ts_reg));
    // R7: forced-on mode drives after one registered edge
    p_oe_forced_r7: assert property (@(posedge clk) disable iff (gsr)
        (ts_reg && ts_mode == TS_ON && ce && !lsr) |=> (pad_oe || !ts_reg));
endmodule

// File: rtl/pio_quad.sv
module pio_quad
    import pio_pkg::*;
#(
    parameter int             NPADS   = 4,
    parameter logic [NPADS-1:0] SR_INIT = '0
) (
    input  logic                 clk,
    input  logic                 gsr,
    input  logic [NPADS/2-1:0]   lsr,
    input  logic [NPADS/2-1:0]   ce,
    input  logic                 latch_mode,
    input  logic                 demux_en,
    input  logic                 ad_strobe,
    input  logic [NPADS-1:0]     pad_in,
    output logic [NPADS-1:0]     in_q,
    output logic [NPADS-1:0]     addr_q,
    output logic [NPADS-1:0]     data_q,
    output logic [2*NPADS-1:0]   ddr_word,
    output logic [2*NPADS-1:0]   gear_word,
    output logic                 gear_valid,
    output logic                 gear_phase,
    input  logic [1:0]           out_mode,
    input  logic                 out_sel,
    input  logic                 out_invert,
    input  logic [1:0]           ts_mode,
    input  logic                 ts_reg,
    input  logic [NPADS-1:0]     core_a,
    input  logic [NPADS-1:0]     core_b,
    input  logic [NPADS-1:0]     core_oe,
    output logic [NPADS-1:0]     pad_out,
    output logic [NPADS-1:0]     pad_oe
);
    localparam int PAIRS = NPADS / 2;

    logic      phase_odd;
    out_mode_e om;
    ts_mode_e  tm;

    assign om = out_mode_e'(out_mode);
    assign tm = ts_mode_e'(ts_mode);

    pio_phase_fsm u_phase (
        .clk        (clk),
        .gsr        (gsr),
        .phase_odd  (phase_odd),
        .word_valid (gear_valid)
    );
    assign gear_phase = phase_odd;

    for (genvar i = 0; i < NPADS; i++) begin : g_pad
        localparam int P = i / 2;

        pio_in_slice #(.INIT(SR_INIT[i])) u_in (
            .clk        (clk),
            .gsr        (gsr),
            .lsr        (lsr[P]),
            .ce         (ce[P]),
            .latch_mode (latch_mode),
            .demux_en   (demux_en),
            .ad_strobe  (ad_strobe),
            .pad        (pad_in[i]),
            .phase_odd  (phase_odd),
            .in_q       (in_q[i]),
            .addr_q     (addr_q[i]),
            .data_q     (data_q[i]),
            .ddr_word   (ddr_word[2*i +: 2]),
            .gear_word  (gear_word[2*i +: 2])
        );

        pio_out_slice #(.INIT(SR_INIT[i])) u_out (
            .clk       (clk),
            .gsr       (gsr),
            .lsr       (lsr[P]),
            .ce        (ce[P]),
            .mode      (om),
            .sel       (out_sel),
            .invert    (out_invert),
            .ts_mode   (tm),
            .ts_reg    (ts_reg),
            .core_a    (core_a[i]),
            .core_b    (core_b[i]),
            .core_oe   (core_oe[i]),
            .phase_odd (phase_odd),
            .pad_out   (pad_out[i]),
            .pad_oe    (pad_oe[i])
        );
    end

    // R1: the cycle after global reset the gearbox restarts in its even phase
    p_gsr_phase_r1: assert property (@(posedge clk)
        gsr |=> (!gear_phase && !gear_valid));
    // R2: a pair under local reset shows cleared flip-flop captures
    p_lsr_clear_r2: assert property (@(posedge clk) disable iff (gsr)
        (lsr[0] && !latch_mode) |=> (latch_mode || in_q[1:0] == SR_INIT[1:0]));
endmodule

// File: tb/tb_pio_quad.sv
`timescale 1ns/100ps
module tb_pio_quad;
    logic       clk = 1'b0;
    logic       gsr = 1'b1;
    logic [1:0] lsr = '0, ce = '0;
    logic       latch_mode = 0, demux_en = 0, ad_strobe = 0;
    logic [3:0] pad_in = '0;
    logic [3:0] in_q, addr_q, data_q;
    logic [7:0] ddr_word, gear_word;
    logic       gear_valid, gear_phase;
    logic [1:0] out_mode = '0, ts_mode = '0;
    logic       out_sel = 0, out_invert = 0, ts_reg = 0;
    logic [3:0] core_a = '0, core_b = '0, core_oe = '0;
    logic [3:0] pad_out, pad_oe;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pio_quad dut (.*);

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] pack2(logic [3:0] lo, logic [3:0] hi);
        logic [7:0] r;
        for (int i = 0; i < 4; i++) begin
            r[2*i]   = lo[i];
            r[2*i+1] = hi[i];
        end
        return r;
    endfunction

    task automatic align_even();
        step();
        while (gear_phase !== 1'b0) step();
    endtask

    task automatic t_reset();
        ts_reg = 1; ts_mode = 2'd2; ce = 2'b11; pad_in = 4'hF; lsr = 2'b00;
        step(); step();
        check("R1 in_q under gsr", {4'h0, in_q}, 8'h00);
        check("R1 pad_out under gsr", {4'h0, pad_out}, 8'h00);
        check("R1 pad_oe under gsr", {4'h0, pad_oe}, 8'h00);
        check("R1 phase under gsr", {6'h0, gear_phase, gear_valid}, 8'h00);
        gsr = 0; pad_in = 4'h0;
        step();
    endtask

    task automatic t_ff_capture();
        latch_mode = 0; ce = 2'b11;
        pad_in = 4'hA; step();
        check("R4 ff capture A", {4'h0, in_q}, 8'h0A);
        pad_in = 4'h5; #0.5;
        check("R4 ff holds between edges", {4'h0, in_q}, 8'h0A);
        step();
        check("R4 ff capture 5", {4'h0, in_q}, 8'h05);
    endtask

    task automatic t_latch();
        latch_mode = 1; ce = 2'b11;
        step();
        pad_in = 4'h6; #0.5;
        check("R4 latch transparent high", {4'h0, in_q}, 8'h06);
        #1.5; pad_in = 4'h9; #0.5;
        check("R4 latch holds low", {4'h0, in_q}, 8'h06);
        step();
        check("R4 latch opens next high", {4'h0, in_q}, 8'h09);
        latch_mode = 0;
    endtask

    task automatic t_ce_hold();
        ce = 2'b11; pad_in = 4'hF; step();
        ce = 2'b01; pad_in = 4'h0; step();
        check("R3 pair1 held, pair0 loads", {4'h0, in_q}, 8'h0C);
        ce = 2'b11; step();
    endtask

    task automatic t_lsr();
        ce = 2'b11; pad_in = 4'hF; lsr = 2'b01; step(); step();
        check("R2 pair0 cleared only", {4'h0, in_q}, 8'h0C);
        lsr = 2'b00; step();
        check("R2 pair0 resumes", {4'h0, in_q}, 8'h0F);
    endtask

    task automatic t_gsr_over_ce();
        ce = 2'b11; pad_in = 4'hF; gsr = 1; step();
        check("R1 gsr overrides ce", {4'h0, in_q}, 8'h00);
        gsr = 0; step();
    endtask

    task automatic t_demux();
        ce = 2'b11; demux_en = 1;
        ad_strobe = 1; pad_in = 4'h3; step();
        ad_strobe = 0; pad_in = 4'hC; step();
        check("R5 address register", {4'h0, addr_q}, 8'h03);
        check("R5 data register", {4'h0, data_q}, 8'h0C);
        ad_strobe = 1; pad_in = 4'h7; step();
        check("R5 data kept in address phase", {4'h0, data_q}, 8'h0C);
        check("R5 new address", {4'h0, addr_q}, 8'h07);
        demux_en = 0; ad_strobe = 0;
    endtask

    task automatic t_out_mux();
        out_mode = 2'd0; out_sel = 0; out_invert = 0; core_a = 4'h3; core_b = 4'hC;
        step();
        check("R6 select a", {4'h0, pad_out}, 8'h03);
        out_sel = 1; step();
        check("R6 select b", {4'h0, pad_out}, 8'h0C);
        out_invert = 1; #0.5;
        check("R6 invert", {4'h0, pad_out}, 8'h03);
        out_invert = 0;
    endtask

    task automatic t_ts();
        ts_reg = 0; ts_mode = 2'd0; core_oe = 4'b0101; #0.5;
        check("R7 active-high direct", {4'h0, pad_oe}, 8'h05);
        ts_mode = 2'd1; #0.5;
        check("R7 active-low direct", {4'h0, pad_oe}, 8'h0A);
        ts_mode = 2'd2; #0.5;
        check("R7 always on", {4'h0, pad_oe}, 8'h0F);
        ts_reg = 1; ts_mode = 2'd0; core_oe = 4'b0011; step();
        check("R7 registered", {4'h0, pad_oe}, 8'h03);
        core_oe = 4'b1100; #0.5;
        check("R7 registered waits for edge", {4'h0, pad_oe}, 8'h03);
        step();
        check("R7 registered update", {4'h0, pad_oe}, 8'h0C);
    endtask

    task automatic t_ddr_in();
        ce = 2'b11; step();
        pad_in = 4'b0110; step();
        pad_in = 4'b1100; step();
        check("R8 ddr word", ddr_word, pack2(4'b0110, 4'b1100));
        pad_in = 4'b1011; step();
        pad_in = 4'b0001; step();
        check("R8 ddr word 2", ddr_word, pack2(4'b1011, 4'b0001));
    endtask

    task automatic t_ddr_out();
        out_mode = 2'd1; out_invert = 0; core_a = 4'h9; core_b = 4'h6;
        step();
        check("R9 high-phase bit", {4'h0, pad_out}, 8'h09);
        #2;
        check("R9 low-phase bit", {4'h0, pad_out}, 8'h06);
        out_mode = 2'd0;
    endtask

    task automatic t_gear_in();
        ce = 2'b11; align_even();
        pad_in = 4'b1010; step();
        pad_in = 4'b0110; step();
        check("R10 valid pulse", {7'h0, gear_valid}, 8'h01);
        check("R10 word lsb first", gear_word, pack2(4'b1010, 4'b0110));
        step();
        check("R10 valid one cycle", {7'h0, gear_valid}, 8'h00);
    endtask

    task automatic t_gear_out();
        out_mode = 2'd2; out_invert = 0; align_even();
        core_a = 4'h5; core_b = 4'hE; step();
        check("R11 first bit", {4'h0, pad_out}, 8'h05);
        core_a = 4'h0; core_b = 4'h0; step();
        check("R11 second bit, core ignored", {4'h0, pad_out}, 8'h0E);
        out_mode = 2'd0;
    endtask

    initial begin
        t_reset();
        t_ff_capture();
        t_latch();
        t_ce_hold();
        t_lsr();
        t_gsr_over_ce();
        t_demux();
        t_out_mux();
        t_ts();
        t_ddr_in();
        t_ddr_out();
        t_gear_in();
        t_gear_out();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule